// File: doc/BRIEF.md
# Secondary Processor Run/Halt/Interrupt Control Register

This block is a 16-bit control word that a host processor writes through two byte-lane enables. Fields in the word drive two control lines into a secondary processor: an active-low reset, and a halt line that requests that processor's bus. The host posts a level-2 interrupt to the secondary processor by writing a set bit in the upper byte. The request clears itself when the secondary processor runs an acknowledge cycle for that level.

During any acknowledge cycle the block also returns the autovector number for the level being acknowledged. The host reads the word back at any time on `rd_data`. Bit 8 of the read value shows whether the interrupt request is still pending. A mask bit, bit 15, keeps a pending request off the interrupt line without discarding it.

Top module: `subctl_top`

## Requirements
- R1: A write merges `wr_data` per lane. `wr_lane[0]` selects bits 7:0 and `wr_lane[1]` selects bits 15:9. A lane that is not enabled keeps its old contents. The new value is visible on `rd_data` from the cycle after the write edge.
- R2: `sub_reset_n` takes the value of written bit 0. A 1 releases the secondary processor from reset and a 0 holds it in reset.
- R3: `sub_halt` takes the value of written bit 1. A 1 requests the secondary processor's bus and halts it, and a 0 releases it.
- R4: `sub_reset_n` and `sub_halt` change only on the edge of a write that enables lane 0. Any other cycle leaves them unchanged.
- R5: Bit 8 is set-only from the host. An upper-lane write with bit 8 = 1 makes the request pending, and `rd_data[8]` reads 1 from the next cycle. An upper-lane write with bit 8 = 0 leaves a pending request in place.
- R6: An acknowledge cycle (`iack` = 1) with `iack_lvl` = 2 clears the pending request on that edge. An acknowledge at any other level leaves it untouched. A set write in the same cycle as a level-2 acknowledge wins, and the request stays pending.
- R7: While `iack` = 1, `iack_vec` equals (0x60 + 4*L)/4 = 0x18 + L, where L is `iack_lvl`. While `iack` = 0, it is 0.
- R8: Bit 15 is a stored mask. `sub_irq` is 1 exactly when the request is pending and bit 15 is 0. While bit 15 is 1, a pending request is kept and not dropped.
- R9: After reset, `rd_data` = 0x0000, `sub_reset_n` = 0, `sub_halt` = 0 and `sub_irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_lane | input | 2 | Byte-lane enables, [1] upper, [0] lower |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Current register value, bit 8 = pending request |
| sub_reset_n | output | 1 | Reset to the secondary processor, active low |
| sub_halt | output | 1 | Halt / bus request to the secondary processor |
| sub_irq | output | 1 | Level-2 interrupt line to the secondary processor |
| iack | input | 1 | Acknowledge cycle from the secondary processor |
| iack_lvl | input | 3 | Level being acknowledged |
| iack_vec | output | 8 | Autovector number returned in the acknowledge cycle |

## Verification
Any wrong state in this block shows up at the ports on the very next cycle. A lost or stuck pending bit appears on `rd_data[8]` and on `sub_irq` straight after the write or acknowledge edge. A control line that drifts away from the stored bits shows up at the next write that enables only the upper lane. At that point the lines must hold while `rd_data` changes. The stimulus deliberately mixes acknowledges at foreign levels, set-and-acknowledge collisions, and mask toggles while a request is pending. Each of these cases hits a different priority in the pending logic.

// File: rtl/subctl_pkg.sv
package subctl_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned HALT_BIT = 1;
  localparam int unsigned REQ_BIT  = 8;
  localparam int unsigned MASK_BIT = 15;
endpackage

// File: rtl/subctl_merge.sv
module subctl_merge #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned LANES = DATA_W / subctl_pkg::BYTE_W
) (
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] merged
);
  localparam int unsigned BW = subctl_pkg::BYTE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (wr_en && wr_lane[l]) merged[l*BW +: BW] = wdata[l*BW +: BW];
      else                     merged[l*BW +: BW] = cur[l*BW +: BW];
    end
  end
endmodule

// File: rtl/subctl_lines.sv
module subctl_lines (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_wr,
  input  logic run_in,
  input  logic halt_in,
  output logic sub_reset_n,
  output logic sub_halt
);
  logic run_d, halt_d;

  always_comb begin
    run_d  = sub_reset_n;
    halt_d = sub_halt;
    if (lo_wr) begin
      run_d  = run_in;
      halt_d = halt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_reset_n <= 1'b0;
      sub_halt    <= 1'b0;
    end else begin
      sub_reset_n <= run_d;
      sub_halt    <= halt_d;
    end
  end
endmodule

// File: rtl/subctl_irq.sv
module subctl_irq #(
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 96,
  parameter int unsigned VEC_STEP = 4,
  parameter int unsigned ACK_LVL  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_req,
  input  logic             mask,
  input  logic             iack,
  input  logic [LVL_W-1:0] iack_lvl,
  output logic             pend,
  output logic             irq,
  output logic [VEC_W-1:0] iack_vec
);
  logic ack_hit, pend_d;
  int unsigned vec_full;

  assign ack_hit = iack && (iack_lvl == LVL_W'(ACK_LVL));

  always_comb begin
    pend_d = pend;
    if (ack_hit) pend_d = 1'b0;
    if (set_req) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  assign irq = pend & ~mask;

  always_comb begin
    vec_full = (VEC_BASE + VEC_STEP * 32'(iack_lvl)) / VEC_STEP;
    iack_vec = iack ? VEC_W'(vec_full) : '0;
  end
endmodule

// File: rtl/subctl_top.sv
module subctl_top #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 96,
  parameter int unsigned VEC_STEP = 4,
  parameter int unsigned ACK_LVL  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_lane,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic              sub_reset_n,
  output logic              sub_halt,
  output logic              sub_irq,
  input  logic              iack,
  input  logic [2:0]        iack_lvl,
  output logic [7:0]        iack_vec
);
  import subctl_pkg::*;

  logic [DATA_W-1:0] ctl_q, ctl_d, merged;
  logic              pend, hi_wr, lo_wr;

  assign hi_wr = wr_en & wr_lane[1];
  assign lo_wr = wr_en & wr_lane[0];

  subctl_merge #(.DATA_W(DATA_W)) u_merge (
    .wr_en  (wr_en),
    .wr_lane(wr_lane),
    .cur    (ctl_q),
    .wdata  (wr_data),
    .merged (merged)
  );

  always_comb begin
    ctl_d          = merged;
    ctl_d[REQ_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  subctl_lines u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_wr      (lo_wr),
    .run_in     (wr_data[RUN_BIT]),
    .halt_in    (wr_data[HALT_BIT]),
    .sub_reset_n(sub_reset_n),
    .sub_halt   (sub_halt)
  );

  subctl_irq #(
    .LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP), .ACK_LVL(ACK_LVL)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (hi_wr & wr_data[REQ_BIT]),
    .mask    (ctl_q[MASK_BIT]),
    .iack    (iack),
    .iack_lvl(iack_lvl),
    .pend    (pend),
    .irq     (sub_irq),
    .iack_vec(iack_vec)
  );

  always_comb begin
    rd_data          = ctl_q;
    rd_data[REQ_BIT] = pend;
  end
endmodule

// File: rtl/subctl_chk.sv
module subctl_chk #(
  parameter int unsigned VEC_BASE = 96,
  parameter int unsigned VEC_STEP = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_lane,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        sub_reset_n,
  input logic        sub_halt,
  input logic        sub_irq,
  input logic        iack,
  input logic [2:0]  iack_lvl,
  input logic [7:0]  iack_vec
);
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_lane[1]) |=> $stable(rd_data[15:9])); // R1
  AST_RUN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lane[0]) |=> (sub_reset_n == $past(wr_data[0]))); // R2
  AST_HALT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lane[0]) |=> (sub_halt == $past(wr_data[1]))); // R3
  AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_lane[0]) |=> ($stable(sub_reset_n) && $stable(sub_halt))); // R4
  AST_REQ_POST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lane[1] && wr_data[8]) |=> rd_data[8]); // R5
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && iack_lvl == 3'd2 && !(wr_en && wr_lane[1] && wr_data[8])) |=> !rd_data[8]); // R6
  AST_VEC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    iack |-> (32'(iack_vec) * VEC_STEP == VEC_BASE + VEC_STEP * 32'(iack_lvl))); // R7
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    sub_irq |-> (rd_data[8] && !rd_data[15])); // R8
endmodule

bind subctl_top subctl_chk #(.VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_chk (.*);

// File: tb/sim_subctl_top.sv
module sim_subctl_top;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_lane = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        sub_reset_n, sub_halt, sub_irq;
  logic        iack = 1'b0;
  logic [2:0]  iack_lvl = '0;
  logic [7:0]  iack_vec;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  logic [15:0] m_reg;
  logic        m_run, m_halt;

  always #(CLK_PER/2) clk = ~clk;

  subctl_top u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_vec(input logic ia, input logic [2:0] lvl);
    return ia ? 8'((32'h60 + 32'd4 * 32'(lvl)) / 32'd4) : 8'h00;
  endfunction

  task automatic model_step(input logic we, input logic [1:0] ln, input logic [15:0] wd,
                            input logic ia, input logic [2:0] lvl);
    logic [15:0] nm;
    nm = m_reg;
    if (we && ln[0]) begin
      nm[7:0] = wd[7:0];
      m_run   = wd[0];
      m_halt  = wd[1];
    end
    if (we && ln[1]) nm[15:9] = wd[15:9];
    if (ia && lvl == 3'd2) nm[8] = 1'b0;
    if (we && ln[1] && wd[8]) nm[8] = 1'b1;
    m_reg = nm;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R1 rd_data"}, rd_data, m_reg);
    chk({tag, " R2 sub_reset_n"}, 16'(sub_reset_n), 16'(m_run));
    chk({tag, " R3 sub_halt"}, 16'(sub_halt), 16'(m_halt));
    chk({tag, " R8 sub_irq"}, 16'(sub_irq), 16'(m_reg[8] & ~m_reg[15]));
  endtask

  // drive at negedge, check vector, advance one edge, check state at next negedge
  task automatic cyc(input logic we, input logic [1:0] ln, input logic [15:0] wd,
                     input logic ia, input logic [2:0] lvl, input string tag);
    wr_en = we; wr_lane = ln; wr_data = wd; iack = ia; iack_lvl = lvl;
    #1;
    chk({tag, " R7 iack_vec"}, 16'(iack_vec), 16'(exp_vec(ia, lvl)));
    @(posedge clk);
    model_step(we, ln, wd, ia, lvl);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED_0042);
    m_reg = '0; m_run = 1'b0; m_halt = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R9 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9 after reset");

    // R2 R3: release reset, then halt
    cyc(1, 2'b01, 16'h0001, 0, 0, "R2 release");
    cyc(1, 2'b01, 16'h0003, 0, 0, "R3 halt");
    // R4 R1: upper-only write leaves lines and low byte alone
    cyc(1, 2'b10, 16'hA400, 0, 0, "R4 upper only");
    // R5: post request, then write 0 to bit 8 must not clear it
    cyc(1, 2'b10, 16'h0100, 0, 0, "R5 post");
    cyc(1, 2'b10, 16'h0000, 0, 0, "R5 zero keeps");
    // R6: foreign level ack ignored, level-2 ack clears
    cyc(0, 2'b00, 16'h0000, 1, 3'd5, "R6 foreign ack");
    cyc(0, 2'b00, 16'h0000, 1, 3'd2, "R6 ack clears");
    // R6: collision, set wins
    cyc(1, 2'b10, 16'h0100, 1, 3'd2, "R6 collide");
    // R8: mask hides pending, unmask restores it
    cyc(1, 2'b10, 16'h8000, 0, 0, "R8 mask on");
    cyc(0, 2'b00, 16'h0000, 0, 0, "R8 masked hold");
    cyc(1, 2'b10, 16'h0000, 0, 0, "R8 mask off");
    // R7: every level
    for (int l = 0; l < 8; l++) cyc(0, 2'b00, 16'h0000, 1, 3'(l), "R7 level");
    // R1: full write then low-only write
    cyc(1, 2'b11, 16'h5A5A, 0, 0, "R1 full");
    cyc(1, 2'b01, 16'h00C4, 0, 0, "R1 low only");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] lv;
      lv = ($urandom % 2 == 0) ? 3'd2 : 3'($urandom);
      cyc(($urandom % 3) != 0, 2'($urandom), 16'($urandom),
          ($urandom % 4) == 0, lv, "random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule